// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends 8-bit characters on an asynchronous serial line. A holding register sits in front of the shift register, so a processor or a DMA engine can queue the next character while the current one is still on the wire. The line rate comes from an external baud tick. Each bit lasts from one tick to the next.

Two flags report progress. `rdy_o` is high while the holding register can take a character. `empty_o` is high only when nothing is queued, nothing is shifting, and the last stop bit has ended. The DMA request is the ready level: each time it is high, the engine writes one character.

Parity is optional, and its polarity is selected by `par_odd_i`. Parity settings are captured when a character moves into the shift register. Clearing the enable discards all queued work and returns the line to idle.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While enabled and idle, the line is high (idle level), `rdy_o` is 1 and `empty_o` is 1. The first cycle after the enable rises already shows both flags high.
- R2: A write with `rdy_o` high is captured at that clock edge, and `rdy_o` reads 0 on the next cycle. The frame's start bit (line low) begins at the next baud tick edge after the capture.
- R3: A character written while another is shifting keeps `rdy_o` low until that earlier frame's stop bit ends.
- R4: At the tick that ends a stop bit, any pending character moves into the shift register on that same edge. Its start bit follows with no idle gap, and `rdy_o` returns to 1.
- R5: `empty_o` is 0 from the cycle after an accepted write until the tick edge that ends the final stop bit, and 1 from that edge on.
- R6: Frame order on the line: start bit 0, then data bit 0 through data bit 7 (least significant first), then the optional parity bit, then stop bit 1. The line changes only at baud tick edges.
- R7: With `par_en_i`=1, a parity bit follows bit 7. With `par_odd_i`=0 it makes the count of ones over data plus parity even; with `par_odd_i`=1 it makes that count odd. With `par_en_i`=0 no parity bit is sent.
- R8: A write while `rdy_o` is 0 is dropped. The queued character is unchanged, and no extra frame appears.
- R9: `dma_req_o` equals `rdy_o` at all times. Writing once per high level of `dma_req_o` streams every character, in order, with none lost.
- R10: With `en_i`=0, from the next cycle on the line is high and `rdy_o`, `empty_o` and `dma_req_o` are 0. Any frame in flight and any queued character are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable |
| wr_i | input | 1 | One-cycle write strobe for the holding register |
| wr_data_i | input | 8 | Character to queue |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| baud_tick_i | input | 1 | One-cycle pulse marking each bit boundary |
| txd_o | output | 1 | Serial line |
| rdy_o | output | 1 | Holding register free |
| empty_o | output | 1 | Nothing queued or shifting, last stop bit complete |
| dma_req_o | output | 1 | DMA transfer request (same level as ready) |

## Verification
Flag changes after a write are due one cycle after the capturing edge. The bench reads them at the following falling edge. Line bits and the ready rise after a frame ends are due on the baud tick edge itself. The bench waits for a clock edge on which the tick was high and samples one nanosecond later or at the next falling edge. The line monitor also checks on every non-tick cycle that the line holds its value, which pins each bit to exactly one tick period. Expected characters are queued when a write is accepted. The monitor compares each decoded frame against them, so a dropped write that leaks shows up as a wrong or extra frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_START = 3'd1,
    TX_DATA  = 3'd2,
    TX_PAR   = 3'd3,
    TX_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic          odd_i,
  output logic          par_o
);
  // even: total ones even; odd: total ones odd
  assign par_o = (^data_i) ^ odd_i;
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (!en_i) begin
      valid_q <= 1'b0;
    end else if (pop_i) begin
      valid_q <= 1'b0;
    end else if (wr_i && !valid_q) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R8: a full holding register keeps its character until it is popped
  a_r8_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_q && !pop_i) |=> (valid_q && data_q == $past(data_q)));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          avail_i,
  input  logic [DW-1:0] data_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          pop_o,
  output logic          line_o,
  output logic          idle_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  tx_state_e     state_q, state_d;
  logic [DW-1:0] shreg_q;
  logic [CW-1:0] cnt_q;
  logic          pen_q, par_q, par_new;
  logic          slot_free, do_load;

  uart_tx_parity #(.DW(DW)) u_par (
    .data_i(data_i),
    .odd_i (par_odd_i),
    .par_o (par_new)
  );

  // shifter can take a new character at a tick when idle or finishing stop
  assign slot_free = (state_q == TX_IDLE) || (state_q == TX_STOP);
  assign do_load   = en_i && tick_i && avail_i && slot_free;
  assign pop_o     = do_load;

  always_comb begin
    state_d = state_q;
    if (tick_i) begin
      unique case (state_q)
        TX_IDLE:  if (avail_i) state_d = TX_START;
        TX_START: state_d = TX_DATA;
        TX_DATA:  if (cnt_q == LAST_BIT) state_d = pen_q ? TX_PAR : TX_STOP;
        TX_PAR:   state_d = TX_STOP;
        TX_STOP:  state_d = avail_i ? TX_START : TX_IDLE;
        default:  state_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      pen_q   <= 1'b0;
      par_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= TX_IDLE;
    end else begin
      state_q <= state_d;
      if (do_load) begin
        shreg_q <= data_i;
        pen_q   <= par_en_i;
        par_q   <= par_new;
        cnt_q   <= '0;
      end else if (tick_i && state_q == TX_DATA) begin
        shreg_q <= shreg_q >> 1;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START: line_o = 1'b0;
      TX_DATA:  line_o = shreg_q[0];
      TX_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign idle_o = (state_q == TX_IDLE);

  // R6: bit state only moves on a baud tick
  a_r6_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(state_q));
  // R2: a load puts the start bit on the line
  a_r2_start_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !line_o);
  // R4: pending character follows the stop bit with no gap
  a_r4_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && state_q == TX_STOP && avail_i) |=> (state_q == TX_START));
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          baud_tick_i,
  output logic          txd_o,
  output logic          rdy_o,
  output logic          empty_o,
  output logic          dma_req_o
);
  logic          hold_valid, pop, sh_idle;
  logic [DW-1:0] hold_data;

  uart_tx_hold #(.DW(DW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .wr_i   (wr_i),
    .data_i (wr_data_i),
    .pop_i  (pop),
    .valid_o(hold_valid),
    .data_o (hold_data)
  );

  uart_tx_shift #(.DW(DW)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (baud_tick_i),
    .avail_i  (hold_valid),
    .data_i   (hold_data),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .pop_o    (pop),
    .line_o   (txd_o),
    .idle_o   (sh_idle)
  );

  assign rdy_o     = en_i && !hold_valid;
  assign empty_o   = en_i && !hold_valid && sh_idle;
  assign dma_req_o = rdy_o;

  // R1: enabling an idle block shows both flags at once
  a_r1_enable_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (rdy_o && empty_o));
  // R3: an accepted write closes the holding register
  a_r3_accept_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && wr_i) |=> !rdy_o);
  // R5: empty implies the line sits at idle level
  a_r5_empty_line_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> txd_o);
  // R10: disable flushes the queue and idles the line
  a_r10_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (txd_o && !hold_valid));
endmodule

// File: tb/sim_uart_tx_dbuf.sv
module sim_uart_tx_dbuf;
  localparam int TICK_DIV = 4;

  logic       clk, rst_n, en, wr, pen, podd, baud_tick;
  logic [7:0] wdata;
  logic       txd, rdy, empty, dma;

  int n_chk  = 0;
  int n_fail = 0;
  int frames = 0;
  logic [9:0] exp_q[$];  // {par_en, par_odd, data}

  uart_tx_dbuf u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .wr_i       (wr),
    .wr_data_i  (wdata),
    .par_en_i   (pen),
    .par_odd_i  (podd),
    .baud_tick_i(baud_tick),
    .txd_o      (txd),
    .rdy_o      (rdy),
    .empty_o    (empty),
    .dma_req_o  (dma)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // line monitor: decodes frames and pops the scoreboard
  logic       m_tk, m_en, m_busy, m_prev, m_par;
  logic [7:0] m_data;
  logic [9:0] m_exp;
  int         m_pos, m_stop;
  initial begin
    m_busy = 1'b0; m_prev = 1'b1; m_pos = 0; m_stop = 9;
    m_data = '0; m_par = 1'b0; m_exp = '0;
  end

  always @(posedge clk) begin
    m_tk = baud_tick;
    m_en = en && rst_n;
    #1;
    if (!m_en) begin
      m_busy = 1'b0;
    end else begin
      if (m_busy) begin
        if (!m_tk) begin
          chk(txd === m_prev, "R6 bit held for one tick", 32'(txd), 32'(m_prev));
        end else begin
          m_pos++;
          if (m_pos <= 8) m_data[m_pos-1] = txd;
          else if (m_pos == 9 && m_exp[9]) m_par = txd;
          else if (m_pos == m_stop) chk(txd === 1'b1, "R6 stop bit high", 32'(txd), 32'd1);
          else begin
            chk(m_data == m_exp[7:0], "R6 data bits lsb first", 32'(m_data), 32'(m_exp[7:0]));
            if (m_exp[9])
              chk(m_par == ((^m_exp[7:0]) ^ m_exp[8]), "R7 parity bit",
                  32'(m_par), 32'((^m_exp[7:0]) ^ m_exp[8]));
            frames++;
            m_busy = 1'b0;
          end
        end
      end
      if (!m_busy && txd === 1'b0) begin
        chk(m_tk, "R2 start bit on baud tick edge", 32'(m_tk), 32'd1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 frame without accepted write", 32'd1, 32'd0);
          m_exp = '0;
        end else begin
          m_exp = exp_q.pop_front();
        end
        m_stop = m_exp[9] ? 10 : 9;
        m_pos  = 0;
        m_busy = 1'b1;
      end
    end
    m_prev = txd;
  end

  task automatic write_byte(input logic [7:0] b, input bit expect_accept);
    wr = 1'b1;
    wdata = b;
    if (expect_accept) exp_q.push_back({pen, podd, b});
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_tick();
    @(posedge clk iff baud_tick);
    @(negedge clk);
  endtask

  task automatic feed(input logic [7:0] b);
    while (!rdy) @(negedge clk);
    chk(dma === rdy, "R9 dma request follows ready", 32'(dma), 32'(rdy));
    write_byte(b, 1'b1);
  endtask

  task automatic wait_empty();
    while (!empty) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f0;
    int zeros;
    rst_n = 1'b0; en = 1'b0; wr = 1'b0; wdata = '0; pen = 1'b0; podd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R10 line high after reset", 32'(txd), 32'd1);
    chk(rdy === 1'b0, "R10 ready low while disabled", 32'(rdy), 32'd0);
    chk(empty === 1'b0, "R10 empty low while disabled", 32'(empty), 32'd0);
    chk(dma === 1'b0, "R9 dma low while disabled", 32'(dma), 32'd0);

    en = 1'b1;
    @(negedge clk);
    chk(rdy === 1'b1, "R1 ready after enable", 32'(rdy), 32'd1);
    chk(empty === 1'b1, "R1 empty after enable", 32'(empty), 32'd1);
    chk(dma === 1'b1, "R9 dma follows ready", 32'(dma), 32'd1);
    chk(txd === 1'b1, "R1 idle line high", 32'(txd), 32'd1);

    // single write, then queue a second during the start bit
    write_byte(8'hA5, 1'b1);
    chk(rdy === 1'b0, "R2 ready low after write", 32'(rdy), 32'd0);
    chk(empty === 1'b0, "R5 empty low after write", 32'(empty), 32'd0);
    wait_tick();
    chk(txd === 1'b0, "R2 start bit at next tick", 32'(txd), 32'd0);
    chk(rdy === 1'b1, "R4 ready back after transfer", 32'(rdy), 32'd1);
    chk(empty === 1'b0, "R5 empty low while shifting", 32'(empty), 32'd0);
    write_byte(8'h3C, 1'b1);
    chk(rdy === 1'b0, "R3 ready low with queued char", 32'(rdy), 32'd0);
    repeat (9) wait_tick();
    chk(txd === 1'b1, "R6 stop bit level", 32'(txd), 32'd1);
    chk(rdy === 1'b0, "R3 ready low until frame end", 32'(rdy), 32'd0);
    chk(empty === 1'b0, "R5 empty low during stop", 32'(empty), 32'd0);
    write_byte(8'hFF, 1'b0);  // dropped
    chk(rdy === 1'b0, "R8 dropped write leaves ready low", 32'(rdy), 32'd0);
    wait_tick();
    chk(txd === 1'b0, "R4 back-to-back start bit", 32'(txd), 32'd0);
    chk(rdy === 1'b1, "R4 ready rises at frame end", 32'(rdy), 32'd1);
    repeat (9) wait_tick();
    chk(empty === 1'b0, "R5 empty low during final stop", 32'(empty), 32'd0);
    wait_tick();
    chk(empty === 1'b1, "R5 empty after final stop", 32'(empty), 32'd1);
    chk(txd === 1'b1, "R5 line idle when empty", 32'(txd), 32'd1);
    chk(frames == 2, "R8 only accepted chars sent", 32'(frames), 32'd2);
    chk(exp_q.size() == 0, "R8 scoreboard drained", 32'(exp_q.size()), 32'd0);

    // parity, even then odd
    pen = 1'b1; podd = 1'b0;
    feed(8'h5A); feed(8'h01); feed(8'h00); feed(8'hFF);
    wait_empty();
    pen = 1'b1; podd = 1'b1;
    feed(8'h00); feed(8'hFF); feed(8'h80); feed(8'h7E);
    wait_empty();
    chk(frames == 10, "R7 parity frames delivered", 32'(frames), 32'd10);

    // DMA-style stream, no parity
    pen = 1'b0; podd = 1'b0;
    f0 = frames;
    for (int i = 0; i < 12; i++) feed(8'(i * 37 + 5));
    wait_empty();
    chk(frames - f0 == 12, "R9 one frame per request", 32'(frames - f0), 32'd12);
    chk(exp_q.size() == 0, "R9 stream drained", 32'(exp_q.size()), 32'd0);

    // disable mid-frame with a character queued
    feed(8'h81);
    feed(8'h42);
    repeat (3) wait_tick();
    f0 = frames;
    en = 1'b0;
    exp_q.delete();
    @(negedge clk);
    chk(txd === 1'b1, "R10 line idle on disable", 32'(txd), 32'd1);
    chk(rdy === 1'b0, "R10 ready low on disable", 32'(rdy), 32'd0);
    chk(empty === 1'b0, "R10 empty low on disable", 32'(empty), 32'd0);
    chk(dma === 1'b0, "R10 dma low on disable", 32'(dma), 32'd0);
    zeros = 0;
    repeat (20) begin
      @(negedge clk);
      if (txd !== 1'b1) zeros++;
    end
    chk(zeros == 0, "R10 line stays high while disabled", 32'(zeros), 32'd0);
    en = 1'b1;
    @(negedge clk);
    chk(rdy === 1'b1, "R10 queue discarded, ready", 32'(rdy), 32'd1);
    chk(empty === 1'b1, "R10 queue discarded, empty", 32'(empty), 32'd1);
    zeros = 0;
    repeat (60) begin
      @(negedge clk);
      if (txd !== 1'b1) zeros++;
    end
    chk(zeros == 0, "R10 discarded char not sent", 32'(zeros), 32'd0);
    chk(frames == f0, "R10 no frame after re-enable", 32'(frames), 32'(f0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule